// File: doc/BRIEF.md
# Asynchronous DRAM Controller with CAS-before-RAS Refresh

This block connects a single host requester to an asynchronous DRAM whose row and column addresses share one set of address pins. The host asks for a read or a write with a valid/ready handshake. Each request moves one word, or a page-mode burst of several words from one row. For a burst the controller holds RAS low and pulses CAS once per column. Read data comes back with a one-cycle valid pulse. The data pins form one bidirectional bus, and the controller drives that bus only while it writes.

The controller also keeps the array alive. An interval timer adds refresh obligations. Each obligation is served at the next idle point as a CAS-before-RAS cycle, so the device's own row counter supplies the row. A mode input picks the refresh style. In distributed mode one refresh is spread evenly per interval. In burst mode a whole array's worth of refreshes runs back to back once per retention period. Strobe spacing comes from cycle-count parameters: precharge, RAS-to-CAS, CAS pulse and access time.

Top module: `dram_ctl`

## Requirements
- R1: While reset is held and right after it, RAS, CAS and write enable are high (inactive), the data bus is released and no read-valid pulse appears.
- R2: A host address is split as `reqAddr = {row, column}` with the row in the upper ROW_W bits. The row is on the address pins when RAS falls and the column is there when CAS falls. CAS falls only while a row is open and at least T_RCD cycles after RAS fell.
- R3: Each read word returns on `rdData` with a single-cycle `rdValid` pulse. The word is the one most recently written to that row and column. It is sampled after CAS has been low for at least T_ACC full cycles.
- R4: For a write, write enable is low and the write word is on the data bus before CAS falls and while it stays low. The device stores that word.
- R5: The controller drives the data bus only while write enable is low. During read column phases the bus is left to the device, and the device never drives it while write enable is low.
- R6: A request carries `reqBurst`, and the beat count is `reqBurst + 1`. The controller opens the row with one RAS fall and issues one CAS pulse per beat. The column starts at the requested column and adds one per beat, wrapping modulo 2^COL_W inside the same row.
- R7: In a write burst, `wrTake` pulses once for each beat after the first. Each beat after the first takes the `reqWdata` value present at the clock edge where `wrTake` is high. The first beat takes the value accepted with the request.
- R8: A refresh cycle lowers CAS at least one cycle before RAS, with write enable high. The device advances its internal refresh row on each such cycle.
- R9: With `refMode = 0` (distributed), one refresh cycle is issued per REF_INTERVAL clock cycles on average.
- R10: With `refMode = 1` (burst), REF_ROWS refresh cycles are issued back to back once every REF_ROWS*REF_INTERVAL cycles, with no host access between them.
- R11: A pending refresh is served before a waiting host request at the next idle point, so refresh keeps its rate under continuous host traffic.
- R12: RAS stays high for at least T_RP cycles between any two RAS-low periods.
- R13: Every device row is refreshed within the retention window, whatever the mode and traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refMode | input | 1 | Refresh style: 0 distributed, 1 burst |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller accepts the request this cycle |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | ROW_W+COL_W | {row, column} of the first word |
| reqBurst | input | BURST_W | Beat count minus one |
| reqWdata | input | DATA_W | Write word (first beat at accept, later beats at wrTake) |
| wrTake | output | 1 | Next write-burst word is taken at this edge |
| rdValid | output | 1 | One-cycle read data valid |
| rdData | output | DATA_W | Read word |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramAddr | output | max(ROW_W,COL_W) | Shared row/column address |
| dramDq | inout | DATA_W | Bidirectional data bus |

## Verification
The assertions check strobe spacing on every cycle: RAS-to-CAS and precharge minimums, CAS leading RAS in refresh, bus drive only under write enable, single-cycle read pulses, refresh taking the idle point ahead of a request, and pages closing only after their last beat. Data integrity, column wrap inside a row, the beat and `wrTake` counts, the refresh rate in each mode, the back-to-back run in burst mode and the per-row retention deadline can only be shown by the bench. The bench's device model and shadow memory observe these over whole traffic scenarios.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_CSET,
    ST_COL,
    ST_PRE,
    ST_REFC,
    ST_REFR
  } ctlState_t;

  typedef struct packed {
    logic loadReq;
    logic loadWd;
    logic incCol;
    logic selCol;
    logic rasOn;
    logic casOn;
    logic weOn;
    logic dqOn;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/dram_ctl_ctrl.sv
module dram_ctl_ctrl
  import dram_ctl_pkg::*;
#(
  parameter int BURST_W      = 3,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_ACC        = 2,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 3,
  parameter int REF_ROWS     = 4096,
  parameter int REF_INTERVAL = 1560
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refMode,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [BURST_W-1:0] reqBurst,
  output logic               reqReady,
  output logic               wrTake,
  output strobe_t            stb
);

  localparam int WAIT_W  = 8;
  localparam int T_CH    = (T_CAS > T_ACC + 1) ? T_CAS : T_ACC + 1;
  localparam int PER_D   = REF_INTERVAL;
  localparam int PER_B   = REF_ROWS * REF_INTERVAL;
  localparam int TMR_W   = $clog2(PER_B + 1);
  localparam int OWE_MAX = 2 * REF_ROWS;
  localparam int OWE_W   = $clog2(OWE_MAX + 1) + 1;

  ctlState_t          state, stNext;
  logic [WAIT_W-1:0]  waitCnt, cntNext;
  logic [BURST_W-1:0] beatsLeft, beatsNext;
  logic               isWrite;
  logic               lastCyc;
  logic [TMR_W-1:0]   timer;
  logic               tick;
  logic [OWE_W-1:0]   owed, owedAdd;
  logic [OWE_W:0]     owedSum;
  logic               take;
  logic               moreBeats;

  assign lastCyc   = (waitCnt == '0);
  assign moreBeats = (beatsLeft != '0);
  assign reqReady  = (state == ST_IDLE) && (owed == '0);
  assign take      = (state == ST_IDLE) && (owed != '0);
  assign wrTake    = (state == ST_COL) && lastCyc && moreBeats && isWrite;

  // refresh interval timer and owed-refresh bookkeeping
  always_comb begin
    tick    = refMode ? (timer >= TMR_W'(PER_B - 1)) : (timer >= TMR_W'(PER_D - 1));
    owedAdd = '0;
    if (tick) owedAdd = refMode ? OWE_W'(REF_ROWS) : OWE_W'(1);
    owedSum = (OWE_W+1)'(owed) + (OWE_W+1)'(owedAdd) - (OWE_W+1)'(take);
    if (owedSum > (OWE_W+1)'(OWE_MAX)) owedSum = (OWE_W+1)'(OWE_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
      owed  <= '0;
    end else begin
      timer <= tick ? '0 : timer + 1'b1;
      owed  <= owedSum[OWE_W-1:0];
    end
  end

  // sequencing of strobe phases
  always_comb begin
    stNext    = state;
    cntNext   = lastCyc ? waitCnt : waitCnt - 1'b1;
    beatsNext = beatsLeft;
    case (state)
      ST_IDLE: begin
        if (owed != '0) begin
          stNext  = ST_REFC;
          cntNext = WAIT_W'(T_CSR - 1);
        end else if (reqValid) begin
          stNext    = ST_ACT;
          cntNext   = WAIT_W'(T_RCD - 1);
          beatsNext = reqBurst;
        end
      end
      ST_ACT: if (lastCyc) begin
        stNext  = ST_CSET;
        cntNext = '0;
      end
      ST_CSET: begin
        stNext  = ST_COL;
        cntNext = WAIT_W'(T_CH - 1);
      end
      ST_COL: if (lastCyc) begin
        if (moreBeats) begin
          stNext    = ST_CSET;
          cntNext   = '0;
          beatsNext = beatsLeft - 1'b1;
        end else begin
          stNext  = ST_PRE;
          cntNext = WAIT_W'(T_RP - 1);
        end
      end
      ST_PRE: if (lastCyc) stNext = ST_IDLE;
      ST_REFC: if (lastCyc) begin
        stNext  = ST_REFR;
        cntNext = WAIT_W'(T_RAS - 1);
      end
      ST_REFR: if (lastCyc) begin
        stNext  = ST_PRE;
        cntNext = WAIT_W'(T_RP - 1);
      end
      default: stNext = ST_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_PRE;
      waitCnt   <= WAIT_W'(T_RP - 1);
      beatsLeft <= '0;
      isWrite   <= 1'b0;
    end else begin
      state     <= stNext;
      waitCnt   <= cntNext;
      beatsLeft <= beatsNext;
      if (reqReady && reqValid) isWrite <= reqWrite;
    end
  end

  // strobes toward the datapath
  always_comb begin
    stb         = '0;
    stb.loadReq = reqReady && reqValid;
    stb.loadWd  = (reqReady && reqValid) || wrTake;
    case (state)
      ST_ACT:  stb.rasOn = 1'b1;
      ST_CSET: begin
        stb.rasOn  = 1'b1;
        stb.selCol = 1'b1;
        stb.weOn   = isWrite;
        stb.dqOn   = isWrite;
      end
      ST_COL: begin
        stb.rasOn   = 1'b1;
        stb.casOn   = 1'b1;
        stb.selCol  = 1'b1;
        stb.weOn    = isWrite;
        stb.dqOn    = isWrite;
        stb.capture = !isWrite && lastCyc;
        stb.incCol  = lastCyc && moreBeats;
      end
      ST_REFC: stb.casOn = 1'b1;
      ST_REFR: begin
        stb.casOn = 1'b1;
        stb.rasOn = 1'b1;
      end
      default: ;
    endcase
  end

  AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACT && $past(state) == ST_IDLE) |-> ($past(owed) == '0)); // R11

  AST_PAGE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE && $past(state) == ST_COL) |-> ($past(beatsLeft) == '0)); // R6

endmodule

// File: rtl/dram_ctl_dpath.sv
module dram_ctl_dpath
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  output logic                   dramRasN,
  output logic                   dramCasN,
  output logic                   dramWeN,
  output logic [ADDR_W-1:0]      dramAddr,
  inout  wire  [DATA_W-1:0]      dramDq
);

  localparam int CNT_W = 8;

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wdReg;
  logic [ADDR_W-1:0] rowExt, colExt;
  logic              rasNQ, casNQ, weNQ, oeQ, capQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dqQ;
  logic [CNT_W-1:0]  rasLowCnt, rasHighCnt;

  always_comb begin
    rowExt = '0;
    colExt = '0;
    rowExt[ROW_W-1:0] = rowReg;
    colExt[COL_W-1:0] = colReg;
  end

  // request latches and column stepping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
      wdReg  <= '0;
    end else begin
      if (stb.loadReq) begin
        rowReg <= reqAddr[ROW_W+COL_W-1:COL_W];
        colReg <= reqAddr[COL_W-1:0];
      end else if (stb.incCol) begin
        colReg <= colReg + 1'b1;
      end
      if (stb.loadWd) wdReg <= reqWdata;
    end
  end

  // registered device pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasNQ <= 1'b1;
      casNQ <= 1'b1;
      weNQ  <= 1'b1;
      oeQ   <= 1'b0;
      capQ  <= 1'b0;
      addrQ <= '0;
      dqQ   <= '0;
    end else begin
      rasNQ <= !stb.rasOn;
      casNQ <= !stb.casOn;
      weNQ  <= !stb.weOn;
      oeQ   <= stb.dqOn;
      capQ  <= stb.capture;
      addrQ <= stb.selCol ? colExt : rowExt;
      dqQ   <= wdReg;
    end
  end

  assign dramRasN = rasNQ;
  assign dramCasN = casNQ;
  assign dramWeN  = weNQ;
  assign dramAddr = addrQ;
  assign dramDq   = oeQ ? dqQ : 'z;

  // read capture at the end of the column strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= capQ;
      if (capQ) rdData <= dramDq;
    end
  end

  // strobe spacing counters at the pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasLowCnt  <= '0;
      rasHighCnt <= '0;
    end else begin
      rasLowCnt  <= rasNQ ? '0 : ((rasLowCnt == '1) ? rasLowCnt : rasLowCnt + 1'b1);
      rasHighCnt <= !rasNQ ? '0 : ((rasHighCnt == '1) ? rasHighCnt : rasHighCnt + 1'b1);
    end
  end

  AST_CAS_AFTER_ROW: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casNQ) && !rasNQ) |-> (rasLowCnt >= CNT_W'(T_RCD))); // R2

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasNQ) |-> (rasHighCnt >= CNT_W'(T_RP))); // R12

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasNQ) && !casNQ) |-> ($past(!casNQ) && weNQ)); // R8

  AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    oeQ |-> !weNQ); // R5

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R3

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 16,
  parameter int BURST_W      = 3,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_ACC        = 2,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 3,
  parameter int REF_ROWS     = 4096,
  parameter int REF_INTERVAL = 1560,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   refMode,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [BURST_W-1:0]     reqBurst,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   wrTake,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  output logic                   dramRasN,
  output logic                   dramCasN,
  output logic                   dramWeN,
  output logic [ADDR_W-1:0]      dramAddr,
  inout  wire  [DATA_W-1:0]      dramDq
);

  strobe_t stb;

  dram_ctl_ctrl #(
    .BURST_W(BURST_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_ACC(T_ACC),
    .T_CSR(T_CSR), .T_RAS(T_RAS), .REF_ROWS(REF_ROWS), .REF_INTERVAL(REF_INTERVAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refMode(refMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .reqReady(reqReady),
    .wrTake(wrTake), .stb(stb)
  );

  dram_ctl_dpath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RP(T_RP), .T_RCD(T_RCD)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramAddr(dramAddr), .dramDq(dramDq)
  );

endmodule

// File: tb/dram_ctl_bench.sv
`timescale 1ns/1ps
module dram_ctl_bench;

  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int T_RP = 2, T_RCD = 2, T_ACC = 2;
  localparam int REF_ROWS = 16, REF_INTERVAL = 40;
  localparam int LIMIT = 3 * REF_ROWS * REF_INTERVAL;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refMode = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [2:0] reqBurst = '0;
  logic [7:0] reqWdata = '0;
  logic       reqReady, wrTake, rdValid;
  logic [7:0] rdData;
  logic       dramRasN, dramCasN, dramWeN;
  logic [3:0] dramAddr;
  wire  [7:0] dramDq;

  always #5 clk = ~clk;

  dram_ctl #(
    .ROW_W(4), .COL_W(4), .DATA_W(8), .BURST_W(3), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CAS(2), .T_ACC(T_ACC), .T_CSR(1), .T_RAS(3),
    .REF_ROWS(REF_ROWS), .REF_INTERVAL(REF_INTERVAL)
  ) u_dram_ctl (
    .clk(clk), .rstN(rstN), .refMode(refMode), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBurst(reqBurst), .reqWdata(reqWdata),
    .wrTake(wrTake), .rdValid(rdValid), .rdData(rdData), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramWeN(dramWeN), .dramAddr(dramAddr), .dramDq(dramDq)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural device model
  logic [7:0] mem [0:ROWS*COLS-1];
  logic [7:0] shadow [0:ROWS*COLS-1];
  int lastRef [0:REF_ROWS-1];
  logic [7:0] modelDq = '0;
  logic drive = 1'b0;
  int cyc = 0;
  bit prevRas = 1, prevCas = 1, rowOpen = 0, rdActive = 0;
  int openRow = 0, rdIdx = 0, casCnt = 0, refRow = 0;
  int rasLowCyc = 0, rasHighCyc = 0;
  int cbrCount = 0, hostRas = 0, casCount = 0, curRun = 0, maxRun = 0;
  int orderErr = 0, noRowErr = 0, contErr = 0, deadErr = 0, wrTakeCnt = 0;
  int minRcd = 1000, minRasHigh = 1000;

  assign dramDq = (drive && !dramCasN) ? modelDq : 'z;

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    for (int r = 0; r < REF_ROWS; r++) lastRef[r] = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (rstN) begin
      if (wrTake) wrTakeCnt++;
      if (prevRas && !dramRasN) begin
        if (rasHighCyc < minRasHigh) minRasHigh = rasHighCyc;
        if (!dramCasN) begin
          if (prevCas || !dramWeN) orderErr++;
          lastRef[refRow] = cyc;
          refRow = (refRow + 1) % REF_ROWS;
          cbrCount++;
          curRun++;
          if (curRun > maxRun) maxRun = curRun;
        end else begin
          rowOpen = 1;
          openRow = int'(dramAddr);
          rasLowCyc = 0;
          hostRas++;
          curRun = 0;
        end
      end
      if (!prevRas && dramRasN) rowOpen = 0;
      if (dramRasN) rasHighCyc++; else rasHighCyc = 0;
      if (!dramRasN) rasLowCyc++;
      if (prevCas && !dramCasN && !dramRasN) begin
        if (!rowOpen || prevRas) noRowErr++;
        casCount++;
        if (rasLowCyc < minRcd) minRcd = rasLowCyc;
        if (!dramWeN) mem[openRow*COLS + int'(dramAddr)] = dramDq;
        else begin
          rdIdx = openRow*COLS + int'(dramAddr);
          rdActive = 1;
          casCnt = 1;
        end
      end else if (!dramCasN && rdActive) casCnt++;
      if (dramCasN) begin
        rdActive = 0;
        drive <= 1'b0;
      end
      if (rdActive && casCnt >= T_ACC) begin
        if (!dramWeN) contErr++;
        drive <= 1'b1;
        modelDq <= mem[rdIdx];
      end
      for (int r = 0; r < REF_ROWS; r++) if (cyc - lastRef[r] > LIMIT) deadErr++;
      prevRas = dramRasN;
      prevCas = dramCasN;
    end
  end

  // reference queue of read words, compared on every clock
  logic [7:0] expQ [$];
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check(0, "R3 unexpected rdValid", 1, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(rdData == e, "R3 read word", int'(rdData), int'(e));
      end
    end
  end

  task automatic request(input bit wr, input int row, input int col, input int beats,
                         input int seed);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = 8'(row*COLS + col);
    reqBurst = 3'(beats - 1);
    reqWdata = 8'(seed);
    for (int k = 0; k < beats; k++) begin
      int idx = row*COLS + ((col + k) % COLS);
      if (wr) shadow[idx] = 8'(seed + 7*k);
      else expQ.push_back(shadow[idx]);
    end
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) begin
      for (int k = 1; k < beats; k++) begin
        reqWdata = 8'(seed + 7*k);
        while (!wrTake) @(negedge clk);
        @(negedge clk);
      end
    end
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  int h0, c0, w0, r0, t0;

  initial begin
    repeat (5) @(negedge clk);
    check(dramRasN && dramCasN && dramWeN && !rdValid, "R1 pins in reset",
          int'({dramRasN, dramCasN, dramWeN, rdValid}), 14);
    rstN = 1'b1;
    @(negedge clk);
    check(dramRasN && dramCasN && dramWeN && !rdValid, "R1 pins after reset",
          int'({dramRasN, dramCasN, dramWeN, rdValid}), 14);

    // single word write then read
    request(1, 3, 5, 1, 8'hA5);
    request(0, 3, 5, 1, 0);
    settle();
    check(expQ.size() == 0, "R4 single read returned", expQ.size(), 0);

    // page-mode write burst and read burst
    h0 = hostRas; c0 = casCount; w0 = wrTakeCnt;
    request(1, 7, 2, 4, 8'h11);
    settle();
    check(hostRas - h0 == 1, "R6 one RAS per write burst", hostRas - h0, 1);
    check(casCount - c0 == 4, "R6 CAS pulses per write burst", casCount - c0, 4);
    check(wrTakeCnt - w0 == 3, "R7 wrTake pulses", wrTakeCnt - w0, 3);
    h0 = hostRas; c0 = casCount;
    request(0, 7, 2, 4, 0);
    settle();
    check(hostRas - h0 == 1, "R6 one RAS per read burst", hostRas - h0, 1);
    check(casCount - c0 == 4, "R6 CAS pulses per read burst", casCount - c0, 4);

    // column wrap inside the row
    request(1, 9, 14, 4, 8'h40);
    request(1, 10, 0, 2, 8'hC0);
    request(0, 9, 14, 4, 0);
    request(0, 10, 0, 2, 0);
    settle();
    check(expQ.size() == 0, "R6 wrap reads returned", expQ.size(), 0);

    // distributed refresh rate when idle
    c0 = cbrCount;
    repeat (400) @(negedge clk);
    check((cbrCount - c0) >= 9 && (cbrCount - c0) <= 11, "R9 distributed rate",
          cbrCount - c0, 10);

    // refresh under continuous host traffic
    c0 = cbrCount; t0 = cyc;
    for (int i = 0; i < 40; i++) request(0, i % ROWS, (3*i) % COLS, 1 + (i % 3), 0);
    r0 = (cyc - t0) / REF_INTERVAL;
    check((cbrCount - c0) >= r0 - 1, "R11 refresh kept under traffic", cbrCount - c0, r0);
    settle();

    // burst refresh mode
    @(negedge clk);
    refMode = 1'b1;
    maxRun = 0;
    c0 = cbrCount;
    for (int i = 0; i < 20; i++) begin
      request(1, i % ROWS, i % COLS, 2, 8'(i*3 + 1));
      repeat (60) @(negedge clk);
    end
    check(maxRun >= REF_ROWS, "R10 back-to-back refresh run", maxRun, REF_ROWS);
    check((cbrCount - c0) >= REF_ROWS && (cbrCount - c0) <= 3*REF_ROWS,
          "R10 burst count per periods", cbrCount - c0, 2*REF_ROWS);
    for (int i = 0; i < 20; i++) request(0, i % ROWS, i % COLS, 2, 0);
    settle();

    check(orderErr == 0, "R8 CAS before RAS refresh order", orderErr, 0);
    check(cbrCount > 0, "R8 refresh cycles seen", cbrCount, 1);
    check(noRowErr == 0, "R2 CAS with open row", noRowErr, 0);
    check(minRcd >= T_RCD, "R2 RAS to CAS spacing", minRcd, T_RCD);
    check(minRasHigh >= T_RP, "R12 precharge spacing", minRasHigh, T_RP);
    check(contErr == 0, "R5 no device drive during write", contErr, 0);
    check(deadErr == 0, "R13 per-row refresh deadline", deadErr, 0);
    check(expQ.size() == 0, "R3 all reads returned", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule